// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Interlock Unit

This block is the hazard control for a five-stage, in-order integer pipeline. Each cycle it looks at the source register fields of the instruction in the execute stage and at the destination fields and write enables of the two older instructions in the memory and write-back stages. From these it picks where each ALU operand comes from: the register file, the result that has just left the ALU, or the value that is being written back. It never takes a value from register 0, and it never takes one from a stage whose write enable is cleared. When both older stages write the operand's register, it chooses the younger producer.

A separate term spots a load in the execute stage whose destination is read by the instruction being decoded. In that case it raises three equal controls. One holds the program counter, one holds the fetch/decode register, and one clears the control bits that go into the decode/execute register, so that a bubble travels down the pipe. The unit has no state, so every output follows its inputs in the same cycle. The pipeline registers, ALU and register file sit around it.

Top module: `hazard_fwd_unit`

## Requirements
- R1: Each operand select is 2 bits: `2'b00` = register file, `2'b10` = EX/MEM result, `2'b01` = MEM/WB result. The code `2'b11` never appears. When all inputs are zero, both selects are `2'b00` and all stall outputs are 0.
- R2: `fwd_a` is `2'b10` exactly when `exmem_wen` is 1, `exmem_rd` is nonzero and `exmem_rd` equals `idex_rs`.
- R3: `fwd_a` is `2'b01` exactly when `memwb_wen` is 1, `memwb_rd` is nonzero, `memwb_rd` equals `idex_rs`, and the R2 condition is false.
- R4: When both producers write the register named by an operand, the select is `2'b10`, the younger producer.
- R5: A destination of register 0 is never forwarded. Such an operand selects `2'b00` whatever the write enables are.
- R6: A producer whose write enable is 0 is never forwarded, even when its destination matches.
- R7: `fwd_b` follows the rules of R2 to R6 with `idex_rt` in place of `idex_rs`, independently of `fwd_a`.
- R8: `pc_hold`, `ifid_hold` and `idex_bubble` are all 1 exactly when `idex_memrd` is 1 and `idex_rt` equals `ifid_rs` or `ifid_rt`, and otherwise they are all 0.
- R9: With `idex_memrd` at 0, no register match raises any stall output.
- R10: All outputs are combinational: they reflect the inputs of the current cycle, with no latency.
- R11: In a load followed at once by a dependent ALU instruction, there is exactly one stall cycle, after which that operand selects `2'b01`. A dependent instruction that follows an ALU producer gets `2'b10` and no stall. A value written back in the cycle the consumer decodes reaches it through the register file with select `2'b00`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idex_rs | input | 5 | First source register of the instruction in EX |
| idex_rt | input | 5 | Second source register of the instruction in EX, also the load destination |
| idex_memrd | input | 1 | Instruction in EX reads memory (load) |
| exmem_rd | input | 5 | Destination register held in EX/MEM |
| exmem_wen | input | 1 | Register write enable held in EX/MEM |
| memwb_rd | input | 5 | Destination register held in MEM/WB |
| memwb_wen | input | 1 | Register write enable held in MEM/WB |
| ifid_rs | input | 5 | First source register of the instruction in ID |
| ifid_rt | input | 5 | Second source register of the instruction in ID |
| fwd_a | output | 2 | Select for ALU operand A |
| fwd_b | output | 2 | Select for ALU operand B and store data |
| pc_hold | output | 1 | Keep the program counter unchanged |
| ifid_hold | output | 1 | Keep the IF/ID register unchanged |
| idex_bubble | output | 1 | Zero the control bits loaded into ID/EX |

## Verification
The bench builds the unit with its default 5-bit register index, which gives 32 registers, register 0 among them. Directed cycles cover each forwarding rule, register 0, cleared enables and both forms of the load-use match. A short load/add/sub/store sequence covers the stall, the MEM/WB path, the EX/MEM path and the write-before-read case. In the random phase, register numbers are drawn from 0 to 3, so that matches between fields, double producers and register-0 destinations occur often.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    // Width of a register index; 2**REG_W architectural registers.
    parameter int REG_W = 5;

    // Number of ALU operands that receive a select.
    localparam int NUM_OPND = 2;

    // Number of decode-stage source fields examined by the interlock.
    localparam int NUM_CONS = 2;

    typedef logic [REG_W-1:0] regidx_t;

    typedef enum logic [1:0] {
        SEL_REGFILE = 2'b00,
        SEL_MEMWB   = 2'b01,
        SEL_EXMEM   = 2'b10
    } opnd_sel_e;

    // Destination information carried by an older pipeline stage.
    typedef struct packed {
        logic    wen;
        regidx_t dst;
    } producer_t;

    // Front-end controls raised by a load-use interlock.
    typedef struct packed {
        logic pc_hold;
        logic ifid_hold;
        logic idex_bubble;
    } stall_ctl_t;

    // A producer can supply a source when it writes a nonzero register equal to that source.
    function automatic logic producer_feeds(producer_t p, regidx_t src);
        return p.wen && (p.dst != '0) && (p.dst == src);
    endfunction

endpackage

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
    import fwd_pkg::*;
(
    input  regidx_t   src,
    input  producer_t young,
    input  producer_t old,
    output opnd_sel_e sel
);

    logic young_hit;
    logic old_hit;

    assign young_hit = producer_feeds(young, src);
    assign old_hit   = producer_feeds(old, src);

    // The younger producer is the later write in program order, so it overrides.
    always_comb begin
        if (young_hit) begin
            sel = SEL_EXMEM;
        end else if (old_hit) begin
            sel = SEL_MEMWB;
        end else begin
            sel = SEL_REGFILE;
        end
    end

endmodule

// File: rtl/load_use_detect.sv
module load_use_detect
    import fwd_pkg::*;
(
    input  logic       ex_is_load,
    input  regidx_t    ex_load_dst,
    input  regidx_t    dec_src [NUM_CONS],
    output stall_ctl_t ctl
);

    logic [NUM_CONS-1:0] field_hit;
    logic                stall;

    for (genvar c = 0; c < NUM_CONS; c++) begin : g_cons
        assign field_hit[c] = (dec_src[c] == ex_load_dst);
    end

    assign stall = ex_is_load && (|field_hit);

    always_comb begin
        ctl.pc_hold     = stall;
        ctl.ifid_hold   = stall;
        ctl.idex_bubble = stall;
    end

endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit
    import fwd_pkg::*;
(
    input  logic [REG_W-1:0] idex_rs,
    input  logic [REG_W-1:0] idex_rt,
    input  logic             idex_memrd,
    input  logic [REG_W-1:0] exmem_rd,
    input  logic             exmem_wen,
    input  logic [REG_W-1:0] memwb_rd,
    input  logic             memwb_wen,
    input  logic [REG_W-1:0] ifid_rs,
    input  logic [REG_W-1:0] ifid_rt,
    output logic [1:0]       fwd_a,
    output logic [1:0]       fwd_b,
    output logic             pc_hold,
    output logic             ifid_hold,
    output logic             idex_bubble
);

    producer_t  exmem_prod;
    producer_t  memwb_prod;
    regidx_t    opnd_src [NUM_OPND];
    opnd_sel_e  opnd_sel [NUM_OPND];
    regidx_t    dec_src  [NUM_CONS];
    stall_ctl_t stall_ctl;

    assign exmem_prod = '{wen: exmem_wen, dst: exmem_rd};
    assign memwb_prod = '{wen: memwb_wen, dst: memwb_rd};

    assign opnd_src[0] = idex_rs;
    assign opnd_src[1] = idex_rt;

    for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
        fwd_operand_sel u_sel (
            .src   (opnd_src[g]),
            .young (exmem_prod),
            .old   (memwb_prod),
            .sel   (opnd_sel[g])
        );
    end

    assign fwd_a = opnd_sel[0];
    assign fwd_b = opnd_sel[1];

    assign dec_src[0] = ifid_rs;
    assign dec_src[1] = ifid_rt;

    load_use_detect u_lud (
        .ex_is_load  (idex_memrd),
        .ex_load_dst (idex_rt),
        .dec_src     (dec_src),
        .ctl         (stall_ctl)
    );

    assign pc_hold     = stall_ctl.pc_hold;
    assign ifid_hold   = stall_ctl.ifid_hold;
    assign idex_bubble = stall_ctl.idex_bubble;

endmodule

// File: rtl/hazard_fwd_chk.sv
module hazard_fwd_chk
    import fwd_pkg::*;
(
    input logic [REG_W-1:0] idex_rs,
    input logic [REG_W-1:0] idex_rt,
    input logic             idex_memrd,
    input logic [REG_W-1:0] exmem_rd,
    input logic             exmem_wen,
    input logic [REG_W-1:0] memwb_rd,
    input logic             memwb_wen,
    input logic [REG_W-1:0] ifid_rs,
    input logic [REG_W-1:0] ifid_rt,
    input logic [1:0]       fwd_a,
    input logic [1:0]       fwd_b,
    input logic             pc_hold,
    input logic             ifid_hold,
    input logic             idex_bubble
);

    always_comb begin
        // R1
        sel_code_legal_chk: assert (fwd_a != 2'b11 && fwd_b != 2'b11);
        // R2
        if (fwd_a == 2'b10) begin
            a_young_src_chk: assert (exmem_wen && exmem_rd != '0 && exmem_rd == idex_rs);
        end
        // R3
        if (fwd_a == 2'b01) begin
            a_old_src_chk: assert (memwb_wen && memwb_rd != '0 && memwb_rd == idex_rs
                                   && !(exmem_wen && exmem_rd == idex_rs));
        end
        // R4
        if (exmem_wen && memwb_wen && exmem_rd == memwb_rd && exmem_rd == idex_rt
            && idex_rt != '0) begin
            b_young_wins_chk: assert (fwd_b == 2'b10);
        end
        // R5
        if (idex_rs == '0) begin
            a_zero_reg_chk: assert (fwd_a == 2'b00);
        end
        // R7
        if (fwd_b != 2'b00) begin
            b_uses_rt_chk: assert ((fwd_b == 2'b10 && exmem_rd == idex_rt)
                                   || (fwd_b == 2'b01 && memwb_rd == idex_rt));
        end
        // R8
        stall_outputs_agree_chk: assert (pc_hold == ifid_hold && ifid_hold == idex_bubble);
        // R8
        if (pc_hold) begin
            stall_has_cause_chk: assert (idex_rt == ifid_rs || idex_rt == ifid_rt);
        end
        // R9
        if (!idex_memrd) begin
            no_load_no_stall_chk: assert (!pc_hold);
        end
    end

endmodule

bind hazard_fwd_unit hazard_fwd_chk u_chk (
    .idex_rs     (idex_rs),
    .idex_rt     (idex_rt),
    .idex_memrd  (idex_memrd),
    .exmem_rd    (exmem_rd),
    .exmem_wen   (exmem_wen),
    .memwb_rd    (memwb_rd),
    .memwb_wen   (memwb_wen),
    .ifid_rs     (ifid_rs),
    .ifid_rt     (ifid_rt),
    .fwd_a       (fwd_a),
    .fwd_b       (fwd_b),
    .pc_hold     (pc_hold),
    .ifid_hold   (ifid_hold),
    .idex_bubble (idex_bubble)
);

// File: tb/hazard_fwd_unit_tb.sv
module hazard_fwd_unit_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] idex_rs = '0, idex_rt = '0, exmem_rd = '0, memwb_rd = '0;
    logic [4:0] ifid_rs = '0, ifid_rt = '0;
    logic       idex_memrd = 1'b0, exmem_wen = 1'b0, memwb_wen = 1'b0;
    logic [1:0] fwd_a, fwd_b;
    logic       pc_hold, ifid_hold, idex_bubble;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    hazard_fwd_unit u_dut (
        .idex_rs(idex_rs), .idex_rt(idex_rt), .idex_memrd(idex_memrd),
        .exmem_rd(exmem_rd), .exmem_wen(exmem_wen),
        .memwb_rd(memwb_rd), .memwb_wen(memwb_wen),
        .ifid_rs(ifid_rs), .ifid_rt(ifid_rt),
        .fwd_a(fwd_a), .fwd_b(fwd_b),
        .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble)
    );

    // Reference: start from the register file, let an older writer override, then a younger one.
    function automatic logic [1:0] ref_sel(input logic ew, input logic [4:0] ed,
                                           input logic mw, input logic [4:0] md,
                                           input logic [4:0] s);
        int pick = 0;
        if (mw && md != 0 && md == s) pick = 1;
        if (ew && ed != 0 && ed == s) pick = 2;
        return (pick == 2) ? 2'b10 : (pick == 1) ? 2'b01 : 2'b00;
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Compare every output against the reference model for the inputs now applied.
    task automatic compare_all(input string tag);
        logic st;
        st = idex_memrd && (idex_rt == ifid_rs || idex_rt == ifid_rt);
        check(tag, "fwd_a", fwd_a, ref_sel(exmem_wen, exmem_rd, memwb_wen, memwb_rd, idex_rs));
        check(tag, "fwd_b", fwd_b, ref_sel(exmem_wen, exmem_rd, memwb_wen, memwb_rd, idex_rt));
        check(tag, "pc_hold", pc_hold, st);
        check(tag, "ifid_hold", ifid_hold, st);
        check(tag, "idex_bubble", idex_bubble, st);
    endtask

    // Apply one cycle of stage contents after the rising edge, sample at the falling edge.
    task automatic cyc(input string tag,
                       input logic [4:0] rs, input logic [4:0] rt, input logic ld,
                       input logic ew, input logic [4:0] ed,
                       input logic mw, input logic [4:0] md,
                       input logic [4:0] frs, input logic [4:0] frt);
        @(posedge clk);
        #1;
        idex_rs = rs; idex_rt = rt; idex_memrd = ld;
        exmem_wen = ew; exmem_rd = ed; memwb_wen = mw; memwb_rd = md;
        ifid_rs = frs; ifid_rt = frt;
        @(negedge clk);
        compare_all(tag);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1: all inputs zero during reset
        check("R1", "fwd_a", fwd_a, 0);
        check("R1", "fwd_b", fwd_b, 0);
        check("R1", "pc_hold", pc_hold, 0);
        rst = 1'b0;

        // R2: younger producer matches rs
        cyc("R2", 5'd3, 5'd1, 0, 1, 5'd3, 0, 5'd0, 5'd20, 5'd21);
        check("R2", "fwd_a code", fwd_a, 2);
        // R6: write enable cleared on a matching producer
        cyc("R6", 5'd3, 5'd3, 0, 0, 5'd3, 0, 5'd3, 5'd20, 5'd21);
        check("R6", "fwd_a code", fwd_a, 0);
        // R3: older producer alone
        cyc("R3", 5'd4, 5'd1, 0, 1, 5'd6, 1, 5'd4, 5'd20, 5'd21);
        check("R3", "fwd_a code", fwd_a, 1);
        // R4: both producers write the same register
        cyc("R4", 5'd5, 5'd5, 0, 1, 5'd5, 1, 5'd5, 5'd20, 5'd21);
        check("R4", "fwd_a code", fwd_a, 2);
        check("R4", "fwd_b code", fwd_b, 2);
        // R5: register 0 destinations with enables set
        cyc("R5", 5'd0, 5'd0, 0, 1, 5'd0, 1, 5'd0, 5'd20, 5'd21);
        check("R5", "fwd_a code", fwd_a, 0);
        check("R5", "fwd_b code", fwd_b, 0);
        // R7: operand B path independent of A
        cyc("R7", 5'd1, 5'd9, 0, 1, 5'd9, 1, 5'd1, 5'd20, 5'd21);
        check("R7", "fwd_b code", fwd_b, 2);
        check("R7", "fwd_a code", fwd_a, 1);
        // R8: load destination matches decode rs, then decode rt
        cyc("R8", 5'd2, 5'd6, 1, 0, 5'd0, 0, 5'd0, 5'd6, 5'd7);
        check("R8", "pc_hold", pc_hold, 1);
        cyc("R8", 5'd2, 5'd6, 1, 0, 5'd0, 0, 5'd0, 5'd7, 5'd6);
        check("R8", "idex_bubble", idex_bubble, 1);
        // R9: matching fields without a load, and a load without a match
        cyc("R9", 5'd2, 5'd6, 0, 0, 5'd0, 0, 5'd0, 5'd6, 5'd6);
        check("R9", "pc_hold", pc_hold, 0);
        cyc("R9", 5'd2, 5'd6, 1, 0, 5'd0, 0, 5'd0, 5'd7, 5'd8);
        check("R9", "ifid_hold", ifid_hold, 0);

        // R11: load r8; add r9,r8,r17; sub r10,r9,r8; store r10 -> [r16]
        cyc("R11", 5'd16, 5'd8, 1, 0, 5'd0, 0, 5'd0, 5'd8, 5'd17);
        check("R11", "stall on load-use", pc_hold, 1);
        cyc("R11", 5'd0, 5'd0, 0, 1, 5'd8, 0, 5'd0, 5'd8, 5'd17);
        check("R11", "single stall", pc_hold, 0);
        cyc("R11", 5'd8, 5'd17, 0, 0, 5'd0, 1, 5'd8, 5'd9, 5'd8);
        check("R11", "load via MEM/WB", fwd_a, 1);
        check("R11", "no stall after ALU op", pc_hold, 0);
        cyc("R11", 5'd9, 5'd8, 0, 1, 5'd9, 0, 5'd0, 5'd0, 5'd0);
        check("R11", "ALU result via EX/MEM", fwd_a, 2);
        check("R11", "written back via regfile", fwd_b, 0);
        cyc("R11", 5'd16, 5'd10, 0, 1, 5'd10, 1, 5'd9, 5'd0, 5'd0);
        check("R11", "store data via EX/MEM", fwd_b, 2);

        // R10: outputs track freshly applied random inputs in the same cycle
        for (int i = 0; i < 400; i++) begin
            cyc("R10", 5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
                1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                5'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
                5'($urandom_range(0, 3)));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule